// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two parallel buses, A and B, of `WIDTH` bits each. Each transfer direction has its own capture register with its own clock. A rising edge of the A-to-B clock stores the word on bus A, and a rising edge of the B-to-A clock stores the word on bus B. Both registers capture on every edge of their clock, whatever state the output controls are in.

An active-low output enable and a direction input decide which bus, if either, the block drives. A per-direction select then chooses what that bus receives: the live word on the opposite bus, passed through combinationally, or the word held in that direction's register. The bidirectional pads are split into an input vector, an output vector and a one-bit output enable per bus, so that the block stays synthesizable and the pad ring owns the tristate. An active-low asynchronous reset clears both registers.

Top module: `regbus_xcvr`

## Requirements
- R1: With `oe_n` low, `dir_b` = 0 asserts `a_oe` only, so bus A is driven from the B side. `dir_b` = 1 asserts `b_oe` only, so bus B is driven from the A side.
- R2: `a_oe` and `b_oe` are never both 1, for any combination of the control inputs.
- R3: With `oe_n` high, both `a_oe` and `b_oe` are 0 (isolation).
- R4: A rising edge of `clk_ab` stores `a_in` in the A-to-B register. While `b_oe` = 1 and `sel_ab` = 1, `b_out` shows that stored word.
- R5: A rising edge of `clk_ba` stores `b_in` in the B-to-A register. While `a_oe` = 1 and `sel_ba` = 1, `a_out` shows that stored word.
- R6: While `b_oe` = 1 and `sel_ab` = 0, `b_out` equals `a_in` in the same cycle, with no register delay.
- R7: While `a_oe` = 1 and `sel_ba` = 0, `a_out` equals `b_in` in the same cycle, with no register delay.
- R8: Capture happens whatever the values of `oe_n` and `dir_b`, including isolation and the direction in which the captured bus is itself driven.
- R9: When both clocks rise together, both registers capture in that same event.
- R10: `rst_n` low clears both registers to zero at once, without a clock edge.
- R11: Between edges of its clock, a register keeps its word. Changes on the bus input and changes of the selects do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low; clears both registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_n | input | 1 | Output enable, active low; high isolates both buses |
| dir_b | input | 1 | 0: drive bus A; 1: drive bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B word |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A word |
| a_in | input | WIDTH | Value seen on bus A pads |
| a_out | output | WIDTH | Value driven onto bus A when a_oe is 1 |
| a_oe | output | 1 | Pad enable for bus A |
| b_in | input | WIDTH | Value seen on bus B pads |
| b_out | output | WIDTH | Value driven onto bus B when b_oe is 1 |
| b_oe | output | 1 | Pad enable for bus B |

## Verification
The bench walks all sixteen control combinations. A decoder that let both pad enables rise together, or that drove a bus during isolation, would show up there as two drivers fighting on the board. It captures words while the outputs are isolated and with both clocks rising together. A design that gated capture with the output enable would then read back stale words, and one that shared a single clock would update only one register. It also changes the live inputs and selects between edges and resets without any clock. A design whose register tracked its input, or whose reset waited for an edge, would show the wrong stored word at the port.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_A    = 2'b01,
        DRV_B    = 2'b10
    } drive_e;

    localparam int NUM_DIRS = 2;
    localparam int DIR_AB   = 0;
    localparam int DIR_BA   = 1;

    function automatic drive_e decode_drive(input logic oe_n, input logic dir_b);
        drive_e res;
        if (oe_n)       res = DRV_NONE;
        else if (dir_b) res = DRV_B;
        else            res = DRV_A;
        return res;
    endfunction

endpackage

// File: rtl/regbus_capture.sv
module regbus_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] held
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } cap_state_t;

    cap_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.word = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign held = state_q.word;

endmodule

// File: rtl/regbus_drive_ctrl.sv
module regbus_drive_ctrl
    import regbus_pkg::*;
(
    input  logic oe_n,
    input  logic dir_b,
    output logic a_oe,
    output logic b_oe
);

    drive_e drv;

    always_comb begin
        drv  = decode_drive(oe_n, dir_b);
        a_oe = (drv == DRV_A);
        b_oe = (drv == DRV_B);
    end

endmodule

// File: rtl/regbus_out_mux.sv
module regbus_out_mux #(
    parameter int WIDTH = 8
) (
    input  logic             use_held,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        y = use_held ? held : live;
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             oe_n,
    input  logic             dir_b,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    logic [NUM_DIRS-1:0]            cap_clk;
    logic [NUM_DIRS-1:0]            use_held;
    logic [NUM_DIRS-1:0][WIDTH-1:0] src_word;
    logic [NUM_DIRS-1:0][WIDTH-1:0] held_word;
    logic [NUM_DIRS-1:0][WIDTH-1:0] mux_word;

    always_comb begin
        cap_clk[DIR_AB]  = clk_ab;
        cap_clk[DIR_BA]  = clk_ba;
        use_held[DIR_AB] = sel_ab;
        use_held[DIR_BA] = sel_ba;
        src_word[DIR_AB] = a_in;
        src_word[DIR_BA] = b_in;
    end

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        regbus_capture #(.WIDTH(WIDTH)) u_cap (
            .clk    (cap_clk[g]),
            .rst_n  (rst_n),
            .bus_in (src_word[g]),
            .held   (held_word[g])
        );
        regbus_out_mux #(.WIDTH(WIDTH)) u_mux (
            .use_held (use_held[g]),
            .live     (src_word[g]),
            .held     (held_word[g]),
            .y        (mux_word[g])
        );
    end

    regbus_drive_ctrl u_drv (
        .oe_n  (oe_n),
        .dir_b (dir_b),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    assign b_out = mux_word[DIR_AB];
    assign a_out = mux_word[DIR_BA];

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             rst_n,
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             oe_n,
    input logic             dir_b,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe
);

    logic seen_ab_q, seen_ba_q;

    always_ff @(posedge clk_ab or negedge rst_n) begin
        if (!rst_n) seen_ab_q <= 1'b0;
        else        seen_ab_q <= 1'b1;
    end

    always_ff @(posedge clk_ba or negedge rst_n) begin
        if (!rst_n) seen_ba_q <= 1'b0;
        else        seen_ba_q <= 1'b1;
    end

    AST_ONE_DRIVER: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !(a_oe && b_oe)); // R2

    AST_ISOLATE: assert property (@(posedge clk_ba) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe)); // R3

    AST_HELD_AB: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (seen_ab_q && b_oe && sel_ab) |-> (b_out == $past(a_in))); // R4

    AST_HELD_BA: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (seen_ba_q && a_oe && sel_ba) |-> (a_out == $past(b_in))); // R5

    AST_LIVE_AB: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> (b_out == a_in)); // R6

    AST_LIVE_BA: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> (a_out == b_in)); // R7

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;

    localparam int W = 8;

    logic         tick = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_ab = 1'b0, clk_ba = 1'b0;
    logic         oe_n = 1'b1, dir_b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 tick = ~tick;

    regbus_xcvr #(.WIDTH(W)) u_regbus_xcvr (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
        .dir_b(dir_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct packed {
        logic         oe_n;
        logic         dir_b;
        logic         sel_ab;
        logic         sel_ba;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ea;
        logic         eb;
        logic [W-1:0] xa;
        logic [W-1:0] xb;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5, 1'b1, 1'b0, 8'hA5, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0, 1'b1, 8'h00, 8'h3C},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'hFF},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 8'h80, 1'b1, 1'b0, 8'h80, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b0, 8'h00, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b0, 8'h00, 8'h00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b0, 8'hFF, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 8'h00, 8'h01}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit do_ab, input bit do_ba);
        #1;
        if (do_ab) clk_ab = 1'b1;
        if (do_ba) clk_ba = 1'b1;
        #1;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #1;
    endtask

    task automatic read_held(output logic [W-1:0] ab_word, output logic [W-1:0] ba_word);
        oe_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
        dir_b = 1'b1; #1; ab_word = b_out;
        dir_b = 1'b0; #1; ba_word = a_out;
    endtask

    initial begin
        repeat (200000) @(posedge tick);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hab, hba;
        #10;
        // R10: reset state of both registers
        read_held(hab, hba);
        check("R10 reset ab", hab, 8'h00);
        check("R10 reset ba", hba, 8'h00);
        rst_n = 1'b1;
        #3;

        // R1 R6 R7: vector table
        for (int i = 0; i < NVEC; i++) begin
            oe_n = TBL[i].oe_n; dir_b = TBL[i].dir_b;
            sel_ab = TBL[i].sel_ab; sel_ba = TBL[i].sel_ba;
            a_in = TBL[i].a; b_in = TBL[i].b;
            #1;
            check("R1 a_oe", {7'd0, a_oe}, {7'd0, TBL[i].ea});
            check("R1 b_oe", {7'd0, b_oe}, {7'd0, TBL[i].eb});
            if (TBL[i].ea) check("R7 live to A", a_out, TBL[i].xa);
            if (TBL[i].eb) check("R6 live to B", b_out, TBL[i].xb);
        end

        // R2 R3: every control combination
        for (int c = 0; c < 16; c++) begin
            {oe_n, dir_b, sel_ab, sel_ba} = 4'(c);
            #1;
            check("R2 one driver", {7'd0, a_oe & b_oe}, 8'h00);
            if (oe_n) check("R3 isolation", {6'd0, a_oe, b_oe}, 8'h00);
        end

        // R4 R11: capture A, then disturb input and select
        oe_n = 1'b0; dir_b = 1'b1; sel_ab = 1'b1; a_in = 8'hC3;
        pulse(1, 0);
        check("R4 held to B", b_out, 8'hC3);
        a_in = 8'h18; sel_ab = 1'b0; #1; sel_ab = 1'b1; #1;
        check("R11 ab hold", b_out, 8'hC3);

        // R5 R8: capture B while bus B itself is driven
        b_in = 8'h6E;
        pulse(0, 1);
        dir_b = 1'b0; sel_ba = 1'b1; b_in = 8'h00; #1;
        check("R5 held to A", a_out, 8'h6E);
        check("R11 ba hold", a_out, 8'h6E);

        // R8 R9: isolation, both clocks together
        oe_n = 1'b1; a_in = 8'h9A; b_in = 8'h47;
        pulse(1, 1);
        a_in = 8'h00; b_in = 8'h00;
        read_held(hab, hba);
        check("R8 R9 isolated ab", hab, 8'h9A);
        check("R8 R9 isolated ba", hba, 8'h47);

        // R10: asynchronous clear with no clock edge
        rst_n = 1'b0; #1;
        read_held(hab, hba);
        check("R10 async clear ab", hab, 8'h00);
        check("R10 async clear ba", hba, 8'h00);
        rst_n = 1'b1; #2;

        // R4: first capture after reset
        a_in = 8'h7F; pulse(1, 0);
        read_held(hab, hba);
        check("R4 after reset ab", hab, 8'h7F);
        check("R11 ba untouched", hba, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule